// File: doc/BRIEF.md
# Framed Serial Control and Readout Port

This block is the digital serial port of a small sampling converter that can share its serial lines with a second converter. A host frames a control write with a falling edge on a write frame input and then clocks ten control bits in on the falling edges of the serial clock. The word reaches the control register only when its address bit matches a strapped address pin. A read is framed by a rising edge on a separate read frame input. The port then drives ten result bits on the rising edges of the serial clock and releases its data line on the eleventh rising edge.

All serial pins are slow compared with the system clock. They are synchronised into the system clock domain, and their edges are detected there. The port keeps a bus-ownership flag. Only the port that accepted the most recent valid control word drives the data line on a read, so two ports can sit on one bus. The analog multiplexer select and the power-mode bits are driven out as plain field outputs.

Top module: `framed_serial_port`

## Requirements
- R1: After reset the control register reads all zeros, the ownership flag is 0 and the data-line enable is 0.
- R2: A falling edge on `wr_frame_i` starts a write. The next ten falling edges of `sclk_i` shift `din_i` in MSB first. After the tenth edge the word is complete.
- R3: Falling `sclk_i` edges after the tenth of a write, such as pulses 11 to 13, leave the register unchanged until the next write frame.
- R4: A complete word whose bit 5 (the address bit) differs from `addr_pin_i` is discarded, and the register keeps its value.
- R5: A complete word whose address bit matches is stored and sets the ownership flag. A complete mismatching word clears the flag. The flag value at the rising edge of `rd_frame_i` decides whether that read drives the data line. A port without ownership keeps the enable at 0 for the whole read.
- R6: The read side ignores `sclk_i` until a rising edge of `rd_frame_i`. That edge captures `result_i`. Rising `sclk_i` edges 1 to 10 then put result bits 9 down to 0 on `dout_o`.
- R7: The eleventh rising `sclk_i` edge of a read drops `dout_oe_o` and clears the read counter. Later rising edges keep the line released until a new read frame.
- R8: A write can run in the same frame as a read. A word completed during a read does not change the drive decision of that read.
- R9: A new falling edge on `wr_frame_i` during a write restarts the bit count. Bits taken before the restart are lost.
- R10: The register layout from bit 9 down to bit 0 is: common-reference select, differential select, software convert, external reference, address, power mode (2 bits), channel (3 bits). `chan_o` mirrors bits 2:0 and `pwr_mode_o` mirrors bits 4:3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sclk_i | input | 1 | Serial clock pin |
| wr_frame_i | input | 1 | Write frame sync; a falling edge starts a write |
| rd_frame_i | input | 1 | Read frame sync; a rising edge starts a read |
| din_i | input | 1 | Serial data in |
| addr_pin_i | input | 1 | Strapped package address |
| result_i | input | 10 | Conversion result to shift out |
| dout_o | output | 1 | Serial data out, 0 when released |
| dout_oe_o | output | 1 | Output enable for the data line driver |
| ctrl_o | output | 10 | Control register |
| chan_o | output | 3 | Channel select field |
| pwr_mode_o | output | 2 | Power mode field |
| owner_o | output | 1 | Bus ownership flag |

## Verification
A write and a read can run in the same frame. The bench does this by starting both frames at the same system cycle, with the write falling edge and the read rising edge together. The write word then completes while the read is still shifting. Ownership changes only after the write completes, so the bench checks each driven bit against the ownership that held before the frame started. It then checks the register and the ownership flag against what the completed word implies for the next frame.

// File: rtl/fsp_pkg.sv
package fsp_pkg;
  localparam int unsigned CTRL_W   = 10;
  localparam int unsigned RES_W    = 10;
  localparam int unsigned ADDR_IDX = 5;
  localparam int unsigned CHAN_W   = 3;
  localparam int unsigned PWR_LSB  = 3;
  localparam int unsigned PWR_W    = 2;
  localparam int unsigned SYNC_N   = 2;
endpackage

// File: rtl/fsp_edge_sync.sv
module fsp_edge_sync #(
  parameter int unsigned N      = 4,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] pin_i,
  output logic [N-1:0] lvl_o,
  output logic [N-1:0] rise_o,
  output logic [N-1:0] fall_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic [STAGES-1:0] sync_q;
    logic              dly_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sync_q <= '0;
        dly_q  <= 1'b0;
      end else begin
        sync_q <= {sync_q[STAGES-2:0], pin_i[g]};
        dly_q  <= sync_q[STAGES-1];
      end
    end
    assign lvl_o[g]  = sync_q[STAGES-1];
    assign rise_o[g] = sync_q[STAGES-1] & ~dly_q;
    assign fall_o[g] = ~sync_q[STAGES-1] & dly_q;
  end
endmodule

// File: rtl/fsp_write_rx.sv
module fsp_write_rx #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         frame_fall_i,
  input  logic         sclk_fall_i,
  input  logic         din_i,
  output logic         word_vld_o,
  output logic [W-1:0] word_o
);
  localparam int unsigned CW = $clog2(W + 1);

  logic          act_q, vld_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= 1'b0;
      vld_q <= 1'b0;
      cnt_q <= '0;
      sh_q  <= '0;
    end else if (frame_fall_i) begin
      // restart wins over a coincident clock edge
      act_q <= 1'b1;
      vld_q <= 1'b0;
      cnt_q <= '0;
      sh_q  <= '0;
    end else begin
      vld_q <= 1'b0;
      if (act_q && sclk_fall_i) begin
        sh_q <= {sh_q[W-2:0], din_i};
        if (cnt_q == CW'(W - 1)) begin
          act_q <= 1'b0;
          vld_q <= 1'b1;
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign word_vld_o = vld_q;
  assign word_o     = sh_q;

  a_r2_cnt_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < CW'(W));
  a_r3_idle_no_word: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!act_q && !frame_fall_i) |=> !word_vld_o);
  a_r9_restart_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_fall_i |=> (cnt_q == '0 && !word_vld_o));
endmodule

// File: rtl/fsp_read_tx.sv
module fsp_read_tx #(
  parameter int unsigned W = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         frame_rise_i,
  input  logic         sclk_rise_i,
  input  logic [W-1:0] result_i,
  input  logic         own_i,
  output logic         dout_o,
  output logic         dout_oe_o
);
  localparam int unsigned CW = $clog2(W + 1);

  logic          armed_q, own_q, dout_q, oe_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      own_q   <= 1'b0;
      dout_q  <= 1'b0;
      oe_q    <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
    end else if (frame_rise_i) begin
      armed_q <= 1'b1;
      own_q   <= own_i;
      dout_q  <= 1'b0;
      oe_q    <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= result_i;
    end else if (armed_q && sclk_rise_i) begin
      if (cnt_q == CW'(W)) begin
        armed_q <= 1'b0;
        oe_q    <= 1'b0;
        dout_q  <= 1'b0;
        cnt_q   <= '0;
      end else begin
        dout_q <= sh_q[W-1];
        sh_q   <= {sh_q[W-2:0], 1'b0};
        oe_q   <= own_q;
        cnt_q  <= cnt_q + 1'b1;
      end
    end
  end

  assign dout_o    = oe_q & dout_q;
  assign dout_oe_o = oe_q;

  a_r7_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (armed_q && sclk_rise_i && !frame_rise_i && cnt_q == CW'(W)) |=> !dout_oe_o);
  a_r5_owner_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dout_oe_o |-> own_q);
  a_r6_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !frame_rise_i) |=> !dout_oe_o);
endmodule

// File: rtl/framed_serial_port.sv
module framed_serial_port
  import fsp_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              wr_frame_i,
  input  logic              rd_frame_i,
  input  logic              din_i,
  input  logic              addr_pin_i,
  input  logic [RES_W-1:0]  result_i,
  output logic              dout_o,
  output logic              dout_oe_o,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [CHAN_W-1:0] chan_o,
  output logic [PWR_W-1:0]  pwr_mode_o,
  output logic              owner_o
);
  localparam int unsigned PIN_N = 4;

  logic [PIN_N-1:0] lvl, rise, fall;
  logic             wr_vld;
  logic [CTRL_W-1:0] wr_word;
  logic [CTRL_W-1:0] ctrl_q;
  logic              owner_q;

  fsp_edge_sync #(.N(PIN_N), .STAGES(SYNC_N)) i_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .pin_i  ({din_i, rd_frame_i, wr_frame_i, sclk_i}),
    .lvl_o  (lvl),
    .rise_o (rise),
    .fall_o (fall)
  );

  fsp_write_rx #(.W(CTRL_W)) i_rx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_fall_i (fall[1]),
    .sclk_fall_i  (fall[0]),
    .din_i        (lvl[3]),
    .word_vld_o   (wr_vld),
    .word_o       (wr_word)
  );

  fsp_read_tx #(.W(RES_W)) i_tx (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .frame_rise_i (rise[2]),
    .sclk_rise_i  (rise[0]),
    .result_i     (result_i),
    .own_i        (owner_q),
    .dout_o       (dout_o),
    .dout_oe_o    (dout_oe_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q  <= '0;
      owner_q <= 1'b0;
    end else if (wr_vld) begin
      if (wr_word[ADDR_IDX] == addr_pin_i) begin
        ctrl_q  <= wr_word;
        owner_q <= 1'b1;
      end else begin
        owner_q <= 1'b0;
      end
    end
  end

  assign ctrl_o     = ctrl_q;
  assign chan_o     = ctrl_q[CHAN_W-1:0];
  assign pwr_mode_o = ctrl_q[PWR_LSB +: PWR_W];
  assign owner_o    = owner_q;

  a_r4_addr_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(ctrl_q) |-> $past(wr_vld && (wr_word[ADDR_IDX] == addr_pin_i)));
  a_r5_owner_grant: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(owner_q) |-> $past(wr_vld));
  a_r8_drive_on_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dout_oe_o) |-> $past(rise[0]));
endmodule

// File: tb/test_framed_serial_port.sv
module test_framed_serial_port;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sclk_i = 1'b0, wr_frame_i = 1'b1, rd_frame_i = 1'b0, din_i = 1'b0;
  logic       addr_pin_i = 1'b0;
  logic [9:0] result_i = '0;
  logic       dout_o, dout_oe_o, owner_o;
  logic [9:0] ctrl_o;
  logic [2:0] chan_o;
  logic [1:0] pwr_mode_o;

  int n_chk = 0, n_bad = 0;
  bit done = 1'b0;
  logic [9:0] m_ctrl = '0;
  logic       m_own = 1'b0;

  always #4 clk_i = ~clk_i;

  framed_serial_port i_framed_serial_port (.*);

  task automatic tick(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit accepts(input logic [9:0] w, input logic pin);
    return w[5] == pin;
  endfunction

  task automatic check_regs(input string req);
    chk(req, 32'(ctrl_o), 32'(m_ctrl));
    chk("R5 owner", 32'(owner_o), 32'(m_own));
    chk("R10 chan", 32'(chan_o), 32'(m_ctrl[2:0]));
    chk("R10 pwr", 32'(pwr_mode_o), 32'(m_ctrl[4:3]));
  endtask

  task automatic frame(input bit do_wr, input logic [9:0] w, input bit do_rd,
                       input logic [9:0] res, input int nclk);
    logic own0;
    own0 = m_own;
    result_i = res;
    if (do_wr) wr_frame_i = 1'b0;
    if (do_rd) rd_frame_i = 1'b1;
    tick(4);
    for (int i = 0; i < nclk; i++) begin
      sclk_i = 1'b1;
      din_i  = (i < 10) ? w[9-i] : 1'($urandom);
      tick(4);
      if (i < 10 && do_rd && own0) begin
        chk("R6 dout_oe", 32'(dout_oe_o), 32'd1);
        chk("R6 dout bit", 32'(dout_o), 32'(res[9-i]));
      end else if (i < 10) begin
        chk("R5/R8 released", 32'(dout_oe_o), 32'd0);
      end else begin
        chk("R7 hi-z after 10", 32'(dout_oe_o), 32'd0);
      end
      sclk_i = 1'b0;
      tick(4);
    end
    wr_frame_i = 1'b1;
    rd_frame_i = 1'b0;
    tick(4);
    if (do_wr && nclk >= 10) begin
      if (accepts(w, addr_pin_i)) begin
        m_ctrl = w;
        m_own  = 1'b1;
      end else begin
        m_own = 1'b0;
      end
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    tick(3);
    rst_ni = 1'b1;
    tick(4);
    // R1 reset state
    check_regs("R1 ctrl reset");
    chk("R1 oe reset", 32'(dout_oe_o), 32'd0);
    // R6: sclk without read frame leaves line released
    frame(1'b0, '0, 1'b0, 10'h3ff, 12);
    chk("R6 no frame no drive", 32'(dout_oe_o), 32'd0);
    // R4: mismatching address discarded
    frame(1'b1, 10'b11_1110_1111, 1'b0, '0, 13);
    check_regs("R4 mismatch kept");
    // R2/R10: matching word, exactly 10 pulses
    frame(1'b1, 10'b10_1001_1101, 1'b0, '0, 10);
    check_regs("R2 accept");
    // R3: 13 pulses, extra din random
    frame(1'b1, 10'b01_0100_0110, 1'b0, '0, 13);
    check_regs("R3 extra pulses");
    // R6/R7: owner read with 13 rising edges
    frame(1'b0, '0, 1'b1, 10'b10_1100_1010, 13);
    chk("R7 released at end", 32'(dout_oe_o), 32'd0);
    // R9: partial write then restarted write
    frame(1'b1, 10'b11_1101_1111, 1'b0, '0, 5);
    check_regs("R9 partial no change");
    frame(1'b1, 10'b00_0000_0101, 1'b0, '0, 13);
    check_regs("R9 restart");
    // R8: write of mismatching word during owner read; read still driven
    frame(1'b1, 10'b00_0010_0000, 1'b1, 10'h2a5, 13);
    check_regs("R8 write in read");
    // R5: non-owner read keeps line released
    frame(1'b0, '0, 1'b1, 10'h155, 12);
    // change strap, then random mix
    addr_pin_i = 1'b1;
    frame(1'b1, 10'b00_0010_0011, 1'b1, 10'h0f0, 11);
    check_regs("R5 regain with pin high");
    for (int k = 0; k < 60; k++) begin
      bit wr, rd;
      logic [9:0] w;
      int n;
      wr = 1'($urandom);
      rd = 1'($urandom);
      w  = 10'($urandom);
      if (k % 7 == 3) addr_pin_i = ~addr_pin_i;
      n  = rd ? 11 + int'($urandom % 3) : 10 + int'($urandom % 4);
      frame(wr, w, rd, 10'($urandom), n);
      check_regs(wr ? "R2/R4 random write" : "R3 random no write");
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule